// File: doc/BRIEF.md
# Slot-Table Bandwidth Arbiter

This block arbitrates a shared bus between up to eight masters using a software-loaded round of sixteen slots. Each slot either names a master or is switched off. A rotating pointer marks the slot where the next search starts. In the same cycle, the arbiter finds the first switched-on slot, in round order from the pointer, whose master is requesting. The grant to that slot's owner is registered at the next clock edge.

A grant stays in place until the owning master reports the end of its transfer with a one-cycle done pulse. The pointer then moves to the slot after the one that was served. A master can own several slots, so bandwidth can be split unevenly. For example, putting the CPU in every even slot gives it half of all grant opportunities when every master is busy. The table is loaded through a plain write port of four 32-bit words.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, `gnt` is all zero, `gnt_valid` is low, every slot is switched off and the search pointer is at slot 0. With all masters requesting, no grant appears until the table is written.
- R2: A write with `cfg_we` high stores `cfg_wdata` in table word `cfg_addr`. In word w, bits 31:24 are slot 4w, bits 23:16 are slot 4w+1, bits 15:8 are slot 4w+2 and bits 7:0 are slot 4w+3. Slots are visited in order 0 to 15 and then wrap back to 0.
- R3: In a slot byte, bit 7 switches the slot on and bits 3:0 hold the master index. Bits 6:4 have no effect. A switched-on slot whose index is 8 or more never grants.
- R4: A switched-off slot never produces a grant. When every slot is switched off, no grant is ever issued.
- R5: When no grant is held, the arbiter picks the first switched-on slot, searching from the pointer, whose master is requesting. At the next edge, `gnt` becomes one-hot on that master, `gnt_valid` goes high and `gnt_slot` shows the slot number. Slots in between are skipped without costing any cycles.
- R6: A held grant stays unchanged until `xfer_done` is sampled high. At that edge, `gnt` and `gnt_valid` clear and the pointer moves to `gnt_slot`+1, modulo 16.
- R7: While no master is requesting, no grant is issued and the pointer does not move.
- R8: `xfer_done` has no effect while no grant is held.
- R9: A table write that lands in the same cycle as a grant decision takes effect only from the next cycle, so that decision uses the old table. A write made while a grant is held does not change that grant.
- R10: If master 0 owns every even slot and other masters own the odd slots, then with all masters requesting, consecutive grants go to consecutive slots and master 0 receives exactly half of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_addr | input | 2 | Table word number |
| cfg_wdata | input | 32 | Table word data, four slot bytes |
| req | input | 8 | Request, one bit per master |
| xfer_done | input | 1 | End-of-transfer pulse from the granted master |
| gnt | output | 8 | One-hot grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_slot | output | 4 | Slot number of the held grant |

## Verification
A table write and a grant decision can fall in the same cycle. The bench provokes this by raising a request and rewriting the only switched-on slot to a different owner on the same clock edge. It then expects the grant to go to the old owner. After that transfer completes, it expects no grant for the old owner and a grant for the new one. The bench also rewrites the table while a grant is held and checks at the ports that the grant does not change. Finally, it pulses done while no grant is held and checks that the next grant still starts from the unmoved pointer.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_HELD = 1'b1
  } arb_state_e;

  // Bit offset of slot j (0 = first visited) inside a table word
  function automatic int field_lsb(input int word_w, input int field_w, input int j);
    return word_w - (j + 1) * field_w;
  endfunction

endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_WORDS      = 4,
  parameter int SLOTS_PER_WORD = 4,
  parameter int FIELD_W        = 8,
  parameter int IDX_W          = 4,
  localparam int WORD_W    = SLOTS_PER_WORD * FIELD_W,
  localparam int NUM_SLOTS = NUM_WORDS * SLOTS_PER_WORD,
  localparam int WADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [WADDR_W-1:0]                wr_addr,
  input  logic [WORD_W-1:0]                 wr_data,
  output logic [NUM_SLOTS-1:0]              slot_on,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]   slot_owner
);
  import slot_arb_pkg::*;

  localparam int ON_BIT = FIELD_W - 1;

  // Bits between the owner index and the switch bit carry no meaning
  logic [NUM_SLOTS-1:0][FIELD_W-1:0] field_view;
  logic spare_field_bits_unused;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit_word;
    assign hit_word = wr_en && (wr_addr == WADDR_W'(w));

    for (genvar j = 0; j < SLOTS_PER_WORD; j++) begin : g_slot
      localparam int SLOT = w * SLOTS_PER_WORD + j;
      localparam int LSB  = field_lsb(WORD_W, FIELD_W, j);

      assign field_view[SLOT] = wr_data[LSB +: FIELD_W];

      always_ff @(posedge clk) begin
        if (rst) begin
          slot_on[SLOT]    <= 1'b0;
          slot_owner[SLOT] <= '0;
        end else if (hit_word) begin
          slot_on[SLOT]    <= field_view[SLOT][ON_BIT];
          slot_owner[SLOT] <= field_view[SLOT][IDX_W-1:0];
        end
      end
    end
  end

  assign spare_field_bits_unused = ^field_view;

  // R1: table comes out of reset fully switched off
  AST_TABLE_CLEAR: assert property (@(posedge clk) $past(rst) |-> slot_on == '0); // R1

endmodule

// File: rtl/slot_search.sv
module slot_search #(
  parameter int NUM_SLOTS   = 16,
  parameter int NUM_MASTERS = 8,
  parameter int IDX_W       = 4,
  localparam int PTR_W  = $clog2(NUM_SLOTS),
  localparam int MIDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [PTR_W-1:0]                 start_ptr,
  input  logic [NUM_SLOTS-1:0]             slot_on,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0]  slot_owner,
  input  logic [NUM_MASTERS-1:0]           req,
  output logic                             pick_found,
  output logic [PTR_W-1:0]                 pick_slot,
  output logic [MIDX_W-1:0]                pick_master
);

  // A slot is eligible when switched on, naming a real master that requests
  logic [NUM_SLOTS-1:0] eligible;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
    logic owner_ok;
    logic owner_req;
    assign owner_ok  = slot_owner[s] < IDX_W'(NUM_MASTERS);
    always_comb begin
      owner_req = 1'b0;
      for (int m = 0; m < NUM_MASTERS; m++) begin
        if (slot_owner[s] == IDX_W'(m)) owner_req = req[m];
      end
    end
    assign eligible[s] = slot_on[s] && owner_ok && owner_req;
  end

  // Rotating first-hit search: scan offsets high to low so the lowest wins
  always_comb begin
    logic [PTR_W-1:0] cand;
    cand       = '0;
    pick_found = 1'b0;
    pick_slot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      cand = start_ptr + PTR_W'(i);
      if (eligible[cand]) begin
        pick_found = 1'b1;
        pick_slot  = cand;
      end
    end
  end

  assign pick_master = slot_owner[pick_slot][MIDX_W-1:0];

  // R4: a pick always lands on a switched-on slot
  AST_PICK_ON: assert property (@(posedge clk) disable iff (rst)
    pick_found |-> slot_on[pick_slot]); // R4

  // R3: a pick never names a master index outside the supported range
  AST_PICK_RANGE: assert property (@(posedge clk) disable iff (rst)
    pick_found |-> slot_owner[pick_slot] < IDX_W'(NUM_MASTERS)); // R3

endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl #(
  parameter int NUM_SLOTS   = 16,
  parameter int NUM_MASTERS = 8,
  localparam int PTR_W  = $clog2(NUM_SLOTS),
  localparam int MIDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pick_found,
  input  logic [PTR_W-1:0]       pick_slot,
  input  logic [MIDX_W-1:0]      pick_master,
  input  logic                   xfer_done,
  output logic [PTR_W-1:0]       start_ptr,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   gnt_valid,
  output logic [PTR_W-1:0]       gnt_slot
);
  import slot_arb_pkg::*;

  arb_state_e state_q;
  logic [NUM_MASTERS-1:0] pick_onehot;

  always_comb begin
    pick_onehot = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (pick_master == MIDX_W'(m)) pick_onehot[m] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OPEN;
      start_ptr <= '0;
      gnt       <= '0;
      gnt_valid <= 1'b0;
      gnt_slot  <= '0;
    end else begin
      case (state_q)
        ST_OPEN: begin
          if (pick_found) begin
            state_q   <= ST_HELD;
            gnt       <= pick_onehot;
            gnt_valid <= 1'b1;
            gnt_slot  <= pick_slot;
          end
        end
        ST_HELD: begin
          if (xfer_done) begin
            state_q   <= ST_OPEN;
            gnt       <= '0;
            gnt_valid <= 1'b0;
            start_ptr <= gnt_slot + PTR_W'(1);
          end
        end
        default: state_q <= ST_OPEN;
      endcase
    end
  end

  AST_GNT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> $countones(gnt) == 1); // R5

  AST_GNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !gnt_valid |-> gnt == '0); // R1

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && !xfer_done |=> gnt_valid && $stable(gnt) && $stable(gnt_slot)); // R6

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && xfer_done |=> !gnt_valid && start_ptr == $past(gnt_slot) + PTR_W'(1)); // R6

  AST_PTR_PARKED: assert property (@(posedge clk) disable iff (rst)
    !gnt_valid && !pick_found |=> !gnt_valid && $stable(start_ptr)); // R7

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int NUM_MASTERS    = 8,
  parameter int NUM_WORDS      = 4,
  parameter int SLOTS_PER_WORD = 4,
  parameter int FIELD_W        = 8,
  parameter int IDX_W          = 4,
  localparam int WORD_W    = SLOTS_PER_WORD * FIELD_W,
  localparam int NUM_SLOTS = NUM_WORDS * SLOTS_PER_WORD,
  localparam int PTR_W     = $clog2(NUM_SLOTS),
  localparam int WADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int MIDX_W    = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [WADDR_W-1:0]     cfg_addr,
  input  logic [WORD_W-1:0]      cfg_wdata,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   xfer_done,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   gnt_valid,
  output logic [PTR_W-1:0]       gnt_slot
);

  logic [NUM_SLOTS-1:0]            slot_on;
  logic [NUM_SLOTS-1:0][IDX_W-1:0] slot_owner;
  logic [PTR_W-1:0]                start_ptr;
  logic                            pick_found;
  logic [PTR_W-1:0]                pick_slot;
  logic [MIDX_W-1:0]               pick_master;

  slot_table #(
    .NUM_WORDS(NUM_WORDS), .SLOTS_PER_WORD(SLOTS_PER_WORD),
    .FIELD_W(FIELD_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .slot_on(slot_on), .slot_owner(slot_owner)
  );

  slot_search #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)
  ) u_search (
    .clk(clk), .rst(rst),
    .start_ptr(start_ptr), .slot_on(slot_on), .slot_owner(slot_owner),
    .req(req),
    .pick_found(pick_found), .pick_slot(pick_slot), .pick_master(pick_master)
  );

  grant_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .pick_found(pick_found), .pick_slot(pick_slot), .pick_master(pick_master),
    .xfer_done(xfer_done),
    .start_ptr(start_ptr),
    .gnt(gnt), .gnt_valid(gnt_valid), .gnt_slot(gnt_slot)
  );

  // R5: a fresh grant goes only to a master that was requesting
  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_valid) |-> ($past(req) & gnt) != '0); // R5

endmodule

// File: tb/slot_arbiter_test.sv
module slot_arbiter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  req = '0;
  logic        xfer_done = 1'b0;
  logic [7:0]  gnt;
  logic        gnt_valid;
  logic [3:0]  gnt_slot;

  int checks = 0;
  int failures = 0;
  bit reported = 1'b0;

  always #5 clk = ~clk;

  slot_arbiter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req(req), .xfer_done(xfer_done),
    .gnt(gnt), .gnt_valid(gnt_valid), .gnt_slot(gnt_slot)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  // Expect no grant for n cycles
  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      step();
      chk(tag, {31'd0, gnt_valid}, 32'd0);
    end
  endtask

  // Wait for a grant, check hold, finish the transfer, check release
  task automatic serve(input string tag, output int m, output int s);
    int n = 0;
    logic [7:0] held;
    while (!gnt_valid && n < 40) begin step(); n++; end
    chk({tag, " grant seen"}, {31'd0, gnt_valid}, 32'd1);
    held = gnt;
    m = -1;
    for (int k = 0; k < 8; k++) if (gnt == 8'(1 << k)) m = k;
    s = int'(gnt_slot);
    step(); step();
    chk({tag, " R6 hold"}, {24'd0, gnt}, {24'd0, held});
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk({tag, " R6 release"}, {23'd0, gnt_valid, gnt}, 32'd0);
  endtask

  task automatic serve_exp(input string tag, input int em, input int es);
    int m, s;
    serve(tag, m, s);
    chk({tag, " master"}, m, em);
    chk({tag, " slot"}, s, es);
  endtask

  task automatic t_reset();
    chk("R1 gnt after reset", {24'd0, gnt}, 32'd0);
    chk("R1 valid after reset", {31'd0, gnt_valid}, 32'd0);
    req = 8'hFF;
    quiet("R1 empty table", 5);
    req = 8'h00;
  endtask

  task automatic t_order();
    cfg_write(2'd0, 32'h80_81_80_82);
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h0);
    cfg_write(2'd3, 32'h0);
    req = 8'hFF;
    serve_exp("R2 slot0", 0, 0);
    serve_exp("R2 slot1", 1, 1);
    serve_exp("R10 repeat owner slot2", 0, 2);
    serve_exp("R2 slot3", 2, 3);
    serve_exp("R2 wrap", 0, 0);
    req = 8'h00;
  endtask

  task automatic t_skip();
    req = 8'h04;
    serve_exp("R5 skip to slot3", 2, 3);
    req = 8'h02;
    serve_exp("R5 skip wrap slot1", 1, 1);
    req = 8'h00;
  endtask

  task automatic t_idle();
    quiet("R7 no request", 5);
    xfer_done = 1'b1; step(); step(); xfer_done = 1'b0;
    chk("R8 done while idle", {31'd0, gnt_valid}, 32'd0);
    req = 8'h01;
    serve_exp("R7 R8 pointer parked", 0, 2);
    req = 8'h00;
  endtask

  task automatic t_format();
    cfg_write(2'd1, 32'h89_73_F3_00);
    req = 8'h08;
    serve_exp("R3 bit7 and spare bits", 3, 6);
    req = 8'h02;
    serve_exp("R3 wrap to slot1", 1, 1);
    serve_exp("R3 index 9 never grants", 1, 1);
    req = 8'h00;
  endtask

  task automatic t_all_off();
    for (int w = 0; w < 4; w++) cfg_write(2'(w), 32'h0);
    req = 8'hFF;
    quiet("R4 all switched off", 20);
    req = 8'h00;
  endtask

  task automatic t_collide();
    cfg_write(2'd0, 32'h80_00_00_00);
    req = 8'h01;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h81_00_00_00;
    step();
    cfg_we = 1'b0;
    chk("R9 decision uses old table", {23'd0, gnt_valid, gnt}, {23'd0, 1'b1, 8'h01});
    cfg_write(2'd0, 32'h82_00_00_00);
    step();
    chk("R9 held grant unchanged", {24'd0, gnt}, 32'h01);
    chk("R9 held slot unchanged", {28'd0, gnt_slot}, 32'd0);
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
    chk("R9 release", {31'd0, gnt_valid}, 32'd0);
    quiet("R9 old owner gone", 8);
    req = 8'h04;
    serve_exp("R9 new owner", 2, 0);
    req = 8'h00;
  endtask

  task automatic t_share();
    int m, s, prev, cpu;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] d = '0;
      for (int j = 0; j < 4; j++) begin
        int sl = w * 4 + j;
        int own = (sl % 2 == 0) ? 0 : ((sl / 2) % 7) + 1;
        d[31 - j * 8 -: 8] = 8'h80 | 8'(own);
      end
      cfg_write(2'(w), d);
    end
    req = 8'hFF;
    prev = 0;
    cpu = 0;
    for (int g = 0; g < 32; g++) begin
      serve("R10 share", m, s);
      chk("R10 consecutive slot", s, (prev + 1) % 16);
      chk("R10 owner", m, (s % 2 == 0) ? 0 : ((s / 2) % 7) + 1);
      if (m == 0) cpu++;
      prev = s;
    end
    chk("R10 cpu half", cpu, 16);
    req = 8'h00;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
    $finish;
  end

  initial begin
    rst = 1'b1;
    step(); step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_order();
    t_skip();
    t_idle();
    t_format();
    t_all_off();
    t_collide();
    t_share();
    report();
    $finish;
  end

endmodule